// File: doc/BRIEF.md
# Serial Delay-Code Register Slave

This block is a two-wire serial bus slave that holds three 6-bit skew-correction codes, one each for the red, green and blue paths of a triple video delay line. A bus master selects one of the three codes with a register byte and then writes a new value or reads the stored value back. The slave answers to one of four 7-bit addresses. The upper five address bits are fixed, and two strap inputs supply the low two bits, so that up to four such slaves can share one bus.

SCL and SDA are not used as clocks. The block samples both lines with its own system clock through synchronizer stages and finds START, STOP and clock edges from the sampled values. SDA is open drain: the block has one output-enable, and asserting it pulls the line low. It uses that output to acknowledge a byte or to send a zero bit. It changes that output only after a fixed number of system clocks has passed since SCL was seen to fall. The three codes are continuous outputs that feed the delay stages directly.

Top module: `i2cdl_top`

## Requirements
- R1: After reset all three codes are 0 and SDA is released (sdaOe = 0).
- R2: The slave acknowledges an address byte whose upper seven bits equal 0b01110 followed by addrStrap[1] and then addrStrap[0]. On any other address it does not acknowledge, and it ignores every byte up to the next START.
- R3: A write is the address byte with R/W = 0 (bit 0), then a register byte, then a data byte. The slave acknowledges all three bytes. The code chosen by register byte bits [1:0] takes data bits [5:0], and data bits [7:6] are ignored. Select value 00 is red, 01 is green and 10 is blue.
- R4: Select value 11 is acknowledged. A write to it changes no code, and a read from it returns 0.
- R5: A read is the address byte with R/W = 0, then the register byte, then a repeated START, then the address byte with R/W = 1. The slave then sends, MSB first, a byte whose bits [7:6] are 0 and whose bits [5:0] are the selected code. The register select from before the repeated START is kept.
- R6: After a master NACK on a read data byte, the slave releases SDA and drives nothing until the next START.
- R7: After a master ACK on a read data byte, the slave sends the same selected code again.
- R8: The slave asserts or removes its SDA drive only while SCL is low, exactly SYNC_STAGES + 1 + HOLD_CYC system clock edges after SCL is driven low.
- R9: A START or STOP at any bit position abandons the byte in progress, with no register write, and returns the slave to address matching.
- R10: A code changes only while SCL is low. The new value appears SYNC_STAGES + 1 edges after SCL falls at the end of the data byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrStrap | input | 2 | Low two bits of the slave address |
| sdaOe | output | 1 | High to pull SDA low |
| codeRed | output | 6 | Red path delay code |
| codeGreen | output | 6 | Green path delay code |
| codeBlue | output | 6 | Blue path delay code |

## Verification
With the default parameters, a change of SDA drive is due on the seventh system clock edge after the bench drives SCL low: two synchronizer stages, one edge-detect register and a four-cycle hold count. A code update is due on the third edge after the final falling edge of the data byte. The bench drives every bus line on a falling system clock edge and counts falling edges before it samples. For each of these two results it reads the output one edge before the change is due and again on the edge where it is due, so that both an early and a late change are caught. All other results (acknowledge bits, read data, code values) are sampled in the middle of the SCL high or low phases, where the bus is settled.

// File: rtl/i2cdl_pkg.sv
package i2cdl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_REG, ST_ACK_R,
    ST_DATA, ST_ACK_D, ST_TX, ST_MACK, ST_IGNORE
  } ctrlStateT;

  typedef enum logic [1:0] {DRV_NONE, DRV_ACK, DRV_TX} driveSelT;

  typedef struct packed {
    logic     clrCnt;
    logic     shiftIn;
    logic     countBit;
    logic     loadTx;
    logic     shiftTx;
    logic     loadPtr;
    logic     writeCode;
    logic     releaseNow;
    driveSelT driveSel;
  } strobeT;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } busEventT;

endpackage

// File: rtl/i2cdl_dpath.sv
module i2cdl_dpath
  import i2cdl_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int NUM_CH      = 3,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  strobeT                   strobe,
  output busEventT                 busEv,
  output logic [7:0]               rxByte,
  output logic [3:0]               bitCnt,
  output logic                     sdaOe,
  output logic                     driveTick,
  output logic [NUM_CH*CODE_W-1:0] codesFlat
);
  localparam int PTR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [HOLD_W-1:0] holdCnt;
  logic [7:0] txShift;
  logic [PTR_W-1:0] ptr;
  logic [CODE_W-1:0] codeReg [NUM_CH];
  logic [CODE_W-1:0] readCode;
  logic driveLevel;

  // Line synchronizers; bus idles high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_comb begin
    busEv.sclRise   = sclS & ~sclD;
    busEv.sclFall   = ~sclS & sclD;
    busEv.startSeen = sclS & sclD & sdaD & ~sdaS;
    busEv.stopSeen  = sclS & sclD & ~sdaD & sdaS;
    busEv.sdaBit    = sdaS;
  end

  // Hold counter: SDA may only move HOLD_CYC clocks after SCL fell.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (busEv.sclFall) holdCnt <= HOLD_W'(HOLD_CYC);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign driveTick = (holdCnt == HOLD_W'(1));

  always_comb begin
    case (strobe.driveSel)
      DRV_ACK: driveLevel = 1'b1;
      DRV_TX:  driveLevel = ~txShift[7];
      default: driveLevel = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaOe <= 1'b0;
    else if (strobe.releaseNow) sdaOe <= 1'b0;
    else if (driveTick) sdaOe <= driveLevel;
  end

  // Receive shifter and bit counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else if (strobe.clrCnt) begin
      bitCnt <= '0;
    end else begin
      if (strobe.shiftIn)  rxByte <= {rxByte[6:0], sdaS};
      if (strobe.countBit) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (strobe.loadPtr) ptr <= rxByte[PTR_W-1:0];
  end

  // Code registers, one per channel.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) codeReg[ch] <= '0;
      else if (strobe.writeCode && ptr == PTR_W'(ch))
        codeReg[ch] <= rxByte[CODE_W-1:0];
    end
    assign codesFlat[ch*CODE_W +: CODE_W] = codeReg[ch];
  end

  always_comb begin
    readCode = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (ptr == PTR_W'(ch)) readCode = codeReg[ch];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (strobe.loadTx) txShift <= 8'(readCode);
    else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
  end

endmodule

// File: rtl/i2cdl_ctrl.sv
module i2cdl_ctrl
  import i2cdl_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b01110
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEventT   busEv,
  input  logic [7:0] rxByte,
  input  logic [3:0] bitCnt,
  input  logic [1:0] addrStrap,
  output strobeT     strobe,
  output ctrlStateT  state
);
  ctrlStateT nxt;
  logic byteFull, addrHit;

  assign byteFull = (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:1] == {ADDR_BASE, addrStrap});

  always_comb begin
    nxt    = state;
    strobe = '0;
    case (state)
      ST_ACK_A, ST_ACK_R, ST_ACK_D: strobe.driveSel = DRV_ACK;
      ST_TX:                        strobe.driveSel = DRV_TX;
      default:                      strobe.driveSel = DRV_NONE;
    endcase

    if (busEv.startSeen) begin
      nxt               = ST_ADDR;
      strobe.clrCnt     = 1'b1;
      strobe.releaseNow = 1'b1;
    end else if (busEv.stopSeen) begin
      nxt               = ST_IDLE;
      strobe.releaseNow = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (busEv.sclRise && !byteFull) begin
            strobe.shiftIn  = 1'b1;
            strobe.countBit = 1'b1;
          end
          if (busEv.sclFall && byteFull) begin
            if (state == ST_ADDR) begin
              nxt = addrHit ? ST_ACK_A : ST_IGNORE;
            end else if (state == ST_REG) begin
              strobe.loadPtr = 1'b1;
              nxt            = ST_ACK_R;
            end else begin
              strobe.writeCode = 1'b1;
              nxt              = ST_ACK_D;
            end
          end
        end
        ST_ACK_A: if (busEv.sclFall) begin
          strobe.clrCnt = 1'b1;
          if (rxByte[0]) begin
            strobe.loadTx = 1'b1;
            nxt           = ST_TX;
          end else begin
            nxt = ST_REG;
          end
        end
        ST_ACK_R: if (busEv.sclFall) begin
          strobe.clrCnt = 1'b1;
          nxt           = ST_DATA;
        end
        ST_ACK_D: if (busEv.sclFall) nxt = ST_IGNORE;
        ST_TX: begin
          if (busEv.sclRise) strobe.countBit = 1'b1;
          if (busEv.sclFall) begin
            if (byteFull) nxt = ST_MACK;
            else strobe.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (busEv.sclRise && busEv.sdaBit) begin
            nxt = ST_IGNORE;
          end else if (busEv.sclFall) begin
            strobe.loadTx = 1'b1;
            strobe.clrCnt = 1'b1;
            nxt           = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

endmodule

// File: rtl/i2cdl_top.sv
module i2cdl_top
  import i2cdl_pkg::*;
#(
  parameter int         HOLD_CYC    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_BASE   = 5'b01110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrStrap,
  output logic       sdaOe,
  output logic [5:0] codeRed,
  output logic [5:0] codeGreen,
  output logic [5:0] codeBlue
);
  localparam int CODE_W = 6;
  localparam int NUM_CH = 3;

  strobeT    strobe;
  busEventT  busEv;
  ctrlStateT ctrlState;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;
  logic driveTick;
  logic [NUM_CH*CODE_W-1:0] codesAll;

  i2cdl_ctrl #(.ADDR_BASE(ADDR_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .busEv(busEv), .rxByte(rxByte),
    .bitCnt(bitCnt), .addrStrap(addrStrap), .strobe(strobe), .state(ctrlState)
  );

  i2cdl_dpath #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .busEv(busEv), .rxByte(rxByte), .bitCnt(bitCnt), .sdaOe(sdaOe),
    .driveTick(driveTick), .codesFlat(codesAll)
  );

  assign codeRed   = codesAll[0*CODE_W +: CODE_W];
  assign codeGreen = codesAll[1*CODE_W +: CODE_W];
  assign codeBlue  = codesAll[2*CODE_W +: CODE_W];

endmodule

// File: rtl/i2cdl_check.sv
module i2cdl_check
  import i2cdl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaOe,
  input logic        driveTick,
  input logic [3:0]  bitCnt,
  input ctrlStateT   ctrlState,
  input logic [17:0] codesAll
);

  // R8: the pull-down only engages while the raw clock line is low
  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R10: codes hold steady across an SCL high phase
  assert_codes_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(codesAll));

  // R9: bit counter never runs past a full byte
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);

  // R5: the two pad bits of a read byte are sent as zeros
  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_TX && bitCnt < 4'd2 && driveTick) |=> sdaOe);

  // R6: no drive while idle or ignoring traffic
  assert_quiet_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlState == ST_IGNORE || ctrlState == ST_IDLE) && driveTick) |=> !sdaOe);

endmodule

bind i2cdl_top i2cdl_check uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .driveTick(driveTick),
  .bitCnt(bitCnt), .ctrlState(ctrlState), .codesAll(codesAll)
);

// File: tb/i2cdl_top_test.sv
module i2cdl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;          // quarter SCL period in system clocks
  localparam int DRIVE_LAT = 7;   // SYNC_STAGES + 1 + HOLD_CYC
  localparam int WRITE_LAT = 3;   // SYNC_STAGES + 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sdaOe;
  logic sdaLine;
  logic [5:0] codeRed, codeGreen, codeBlue;
  int nVec = 0;
  int nFail = 0;
  int expR = 0, expG = 0, expB = 0;

  assign sdaLine = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cdl_top uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrStrap(strap),
    .sdaOe(sdaOe), .codeRed(codeRed), .codeGreen(codeGreen), .codeBlue(codeBlue)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    b = sdaLine; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic highThenFall(input logic b);
    sdaM = b; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    acked = (b == 1'b0);
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(!mAck);
  endtask

  function automatic logic [7:0] addrByte(input logic rw);
    return {5'b01110, strap, rw};
  endfunction

  task automatic checkCodes(input string tag);
    check(codeRed == 6'(expR), {tag, " red"}, codeRed, expR);
    check(codeGreen == 6'(expG), {tag, " green"}, codeGreen, expG);
    check(codeBlue == 6'(expB), {tag, " blue"}, codeBlue, expB);
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [7:0] d, input string tag);
    bit a0, a1, a2;
    i2cStart();
    writeByte(addrByte(1'b0), a0);
    writeByte({6'b0, sel}, a1);
    writeByte(d, a2);
    i2cStop();
    check(a0 && a1 && a2, {tag, " acks"}, {a0, a1, a2}, 7);
  endtask

  task automatic doRead(input logic [1:0] sel, output logic [7:0] v, input string tag);
    bit a0, a1, a2;
    i2cStart();
    writeByte(addrByte(1'b0), a0);
    writeByte({6'b0, sel}, a1);
    i2cStart();
    writeByte(addrByte(1'b1), a2);
    readByte(1'b0, v);
    check(a0 && a1 && a2, {tag, " acks"}, {a0, a1, a2}, 7);
  endtask

  task automatic testReset();
    check(sdaOe == 1'b0, "R1 sda released", sdaOe, 0);
    checkCodes("R1 reset");
  endtask

  task automatic testWrite();
    doWrite(2'b00, 8'd10, "R3 write red");
    expR = 10;
    checkCodes("R3 after red");
    doWrite(2'b01, 8'hEA, "R3 write green");
    expG = 42;
    checkCodes("R3 green pad ignored");
    doWrite(2'b10, 8'd63, "R3 write blue");
    expB = 63;
    checkCodes("R3 after blue");
  endtask

  task automatic testRead();
    logic [7:0] v;
    logic [7:0] tail;
    doRead(2'b01, v, "R5 read green");
    check(v == 8'd42, "R5 green data", v, 42);
    i2cStop();
    doRead(2'b00, v, "R5 read red");
    check(v == 8'd10, "R5 red data", v, 10);
    tick(DRIVE_LAT + 2);
    check(sdaOe == 1'b0, "R6 released after nack", sdaOe, 0);
    readByte(1'b0, tail);
    check(tail == 8'hFF, "R6 silent after nack", tail, 255);
    i2cStop();
  endtask

  task automatic testReadAck();
    logic [7:0] v1, v2;
    bit a0, a1, a2;
    i2cStart();
    writeByte(addrByte(1'b0), a0);
    writeByte(8'd2, a1);
    i2cStart();
    writeByte(addrByte(1'b1), a2);
    readByte(1'b1, v1);
    readByte(1'b0, v2);
    i2cStop();
    check(a0 && a1 && a2, "R7 acks", {a0, a1, a2}, 7);
    check(v1 == 8'd63, "R7 first byte", v1, 63);
    check(v2 == 8'd63, "R7 repeated byte", v2, 63);
  endtask

  task automatic testMismatch();
    bit a0, a1, a2;
    i2cStart();
    writeByte(8'h70, a0);   // 0x38 with write, strap is 01
    writeByte(8'd0, a1);
    writeByte(8'd5, a2);
    i2cStop();
    check(!a0, "R2 no ack on other address", a0, 0);
    check(!a1 && !a2, "R2 later bytes ignored", {a1, a2}, 0);
    checkCodes("R2 unchanged");
    strap = 2'b10;
    doWrite(2'b00, 8'd33, "R2 strap 10 write");
    expR = 33;
    checkCodes("R2 strap 10");
  endtask

  task automatic testBadSel();
    logic [7:0] v;
    doWrite(2'b11, 8'd7, "R4 write sel 3");
    checkCodes("R4 no change");
    doRead(2'b11, v, "R4 read sel 3");
    i2cStop();
    check(v == 8'd0, "R4 read zero", v, 0);
  endtask

  task automatic testAbort();
    bit a0, a1, a2;
    i2cStart();
    writeByte(addrByte(1'b0), a0);
    writeByte(8'd0, a1);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    i2cStart();
    writeByte(addrByte(1'b0), a0);
    writeByte(8'd1, a1);
    writeByte(8'd17, a2);
    i2cStop();
    expG = 17;
    check(a0 && a1 && a2, "R9 restart acks", {a0, a1, a2}, 7);
    checkCodes("R9 after restart");
    i2cStart();
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    i2cStop();
    checkCodes("R9 after stop");
    doWrite(2'b10, 8'd5, "R9 write after stop");
    expB = 5;
    checkCodes("R9 recovered");
  endtask

  task automatic testTiming();
    logic [7:0] ab;
    logic [7:0] d;
    logic b;
    bit a1;
    ab = addrByte(1'b0);
    d = 8'd21;
    i2cStart();
    for (int i = 7; i >= 1; i--) sendBit(ab[i]);
    highThenFall(ab[0]);
    sdaM = 1'b1;
    tick(DRIVE_LAT - 1);
    check(sdaOe == 1'b0, "R8 ack not early", sdaOe, 0);
    tick(1);
    check(sdaOe == 1'b1, "R8 ack on time", sdaOe, 1);
    tick(2*Q - DRIVE_LAT);
    sclM = 1'b1; tick(Q);
    check(sdaLine == 1'b0, "R2 address ack", sdaLine, 0);
    tick(Q);
    sclM = 1'b0;
    tick(DRIVE_LAT - 1);
    check(sdaOe == 1'b1, "R8 release not early", sdaOe, 1);
    tick(1);
    check(sdaOe == 1'b0, "R8 release on time", sdaOe, 0);
    tick(Q - DRIVE_LAT);
    writeByte(8'd0, a1);
    check(a1, "R3 register ack", a1, 1);
    for (int i = 7; i >= 1; i--) sendBit(d[i]);
    highThenFall(d[0]);
    sdaM = 1'b1;
    tick(WRITE_LAT - 1);
    check(codeRed == 6'(expR), "R10 code not early", codeRed, expR);
    tick(1);
    expR = 21;
    check(codeRed == 6'(expR), "R10 code on time", codeRed, expR);
    tick(Q - WRITE_LAT);
    recvBit(b);
    check(b == 1'b0, "R3 data ack", b, 0);
    i2cStop();
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    testReset();
    testWrite();
    testRead();
    testReadAck();
    testMismatch();
    testBadSel();
    testAbort();
    testTiming();
    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nVec++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule